// File: doc/BRIEF.md
# External DMA Request Detector and Cycle Launcher

This block watches an active-low DMA request pin from outside the chip and turns a request into the start of a DMA bus cycle. The pin is first brought into the clock domain through a synchronizer. A configuration input selects how a request is recognised: either a high-to-low transition of the pin, or the pin simply being held low. After a request is recognised, the block waits a fixed minimum latency and then raises a one-cycle cycle-start pulse. The bus side reports the end of each cycle with a cycle-done pulse.

Some cycles carry no data. When the channel runs single-address transfers in burst mode, the first bus cycle of each new burst sequence is a dummy cycle. The block marks that cycle with a dummy flag. After the dummy cycle completes, the block launches the data cycle by itself without waiting for a new request. Dual-address transfers and cycle-steal transfers never get a dummy cycle. Bus timing, wait states and data movement belong to other blocks.

Top module: `dreq_launcher`

## Requirements
- R1: While reset is high and afterwards with the pin held high, `cyc_start` and `cyc_dummy` stay low.
- R2: The pin passes through a two-flop synchronizer, and the launch latency is three clock cycles. A request is recognised on the third rising edge after the pin falls. `cyc_start` then rises after the sixth rising edge counted from the pin falling.
- R3: `cyc_start` is high for exactly one cycle. Two starts are always separated by at least four rising edges. No new start is issued until the current cycle has received its `cyc_done`.
- R4: In edge mode (`det_level`=0), each falling edge of the pin gives one request, and holding the pin low gives no further launches. Any number of falling edges that arrive while a cycle is waiting or running merge into one pending request. That pending request is launched on the fifth rising edge counted from the edge that samples `cyc_done`.
- R5: In level mode (`det_level`=1), a new launch follows every `cyc_done` for as long as the synchronized pin stays low. That start rises on the fifth rising edge counted from the `cyc_done` edge. Once the pin is high, no further launches occur.
- R6: With `single_addr`=1 and `burst`=1, the first cycle of a new sequence starts with `cyc_dummy`=1. The flag stays high until its `cyc_done` and is low after that edge. The data cycle is then started without a new request, on the fourth rising edge counted from that `cyc_done` edge, with `cyc_dummy`=0.
- R7: With `single_addr`=0 (dual address) or `burst`=0 (cycle steal), `cyc_dummy` is never set.
- R8: A sequence continues as long as every `cyc_done` is directly followed by a launch. Only the first cycle of a sequence is a dummy cycle. A sequence ends when the launcher is idle for a cycle with no request, and the next sequence again starts with a dummy cycle.
- R9: While `en`=0 nothing is launched. A falling edge seen while `en`=0 is held and launched on the fourth rising edge after `en` returns to 1.
- R10: `cyc_done` has no effect while no cycle is running. This holds both when the launcher is idle and during the latency wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; gates new launches |
| req_n | input | 1 | Asynchronous active-low external request pin |
| det_level | input | 1 | 1 = low-level detection, 0 = falling-edge detection |
| single_addr | input | 1 | 1 = single-address transfers, 0 = dual-address |
| burst | input | 1 | 1 = burst, 0 = cycle steal |
| cyc_done | input | 1 | One-cycle pulse marking the end of the running bus cycle |
| cyc_start | output | 1 | Registered one-cycle pulse launching a bus cycle |
| cyc_dummy | output | 1 | Registered flag: the current cycle is a dummy cycle |

## Verification
The assertions check rules that can be judged on every cycle:
- `cyc_start` is a single-cycle pulse, and a counter confirms the minimum spacing between starts.
- The dummy flag only rises together with a start and only when single-address burst was selected.
- The dummy flag always drops after its done pulse.

Exact latencies need directed scenarios in the bench, which count the edges from the pin falling, from the done pulse or from re-enabling. The bench scenarios also show that repeated falling edges merge into one pending request, that level mode relaunches, and where a burst sequence begins and ends.

// File: rtl/dreq_launcher_pkg.sv
package dreq_launcher_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_LAUNCH_LAT  = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BUSY = 2'd2
  } launch_st_e;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RESET_VAL;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RESET_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dreq_detect.sv
module dreq_detect (
  input  logic clk,
  input  logic rst,
  input  logic pin_sync,
  input  logic det_level,
  input  logic take,
  output logic req_avail
);
  logic prev_q;
  logic pend_q;
  logic fall;

  // falling edge of the synchronized, active-low pin
  assign fall = prev_q & ~pin_sync;

  always_comb begin
    if (det_level) req_avail = ~pin_sync;
    else           req_avail = pend_q | fall;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_sync;
      if (det_level) pend_q <= 1'b0;
      else           pend_q <= (pend_q | fall) & ~take;
    end
  end
endmodule

// File: rtl/dreq_seq.sv
module dreq_seq
  import dreq_launcher_pkg::*;
#(
  parameter int unsigned LAUNCH_LAT = DEF_LAUNCH_LAT
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic req_avail,
  input  logic single_addr,
  input  logic burst,
  input  logic cyc_done,
  output logic take,
  output logic cyc_start,
  output logic cyc_dummy
);
  localparam int unsigned CW = $clog2(LAUNCH_LAT + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(LAUNCH_LAT - 1);

  launch_st_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          seq_q;
  logic          first_q;

  assign take = (state_q == ST_IDLE) && en && req_avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      seq_q     <= 1'b0;
      first_q   <= 1'b0;
      cyc_start <= 1'b0;
      cyc_dummy <= 1'b0;
    end else begin
      cyc_start <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (take) begin
            state_q <= ST_WAIT;
            cnt_q   <= CNT_LOAD;
            first_q <= ~seq_q;
            seq_q   <= 1'b1;
          end else begin
            seq_q   <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) begin
            state_q   <= ST_BUSY;
            cyc_start <= 1'b1;
            cyc_dummy <= first_q & single_addr & burst;
            first_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_BUSY: begin
          if (cyc_done) begin
            cyc_dummy <= 1'b0;
            if (cyc_dummy) begin
              // dummy cycle finished: data cycle is owed to the same request
              state_q <= ST_WAIT;
              cnt_q   <= CNT_LOAD;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dreq_launcher.sv
module dreq_launcher
  import dreq_launcher_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned LAUNCH_LAT  = DEF_LAUNCH_LAT
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic req_n,
  input  logic det_level,
  input  logic single_addr,
  input  logic burst,
  input  logic cyc_done,
  output logic cyc_start,
  output logic cyc_dummy
);
  logic pin_sync;
  logic req_avail;
  logic take;

  dreq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (req_n),
    .dout (pin_sync)
  );

  dreq_detect u_detect (
    .clk       (clk),
    .rst       (rst),
    .pin_sync  (pin_sync),
    .det_level (det_level),
    .take      (take),
    .req_avail (req_avail)
  );

  dreq_seq #(.LAUNCH_LAT(LAUNCH_LAT)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .req_avail   (req_avail),
    .single_addr (single_addr),
    .burst       (burst),
    .cyc_done    (cyc_done),
    .take        (take),
    .cyc_start   (cyc_start),
    .cyc_dummy   (cyc_dummy)
  );
endmodule

// File: rtl/dreq_launcher_chk.sv
module dreq_launcher_chk #(
  parameter int unsigned LAUNCH_LAT = 3
) (
  input logic clk,
  input logic rst,
  input logic single_addr,
  input logic burst,
  input logic cyc_done,
  input logic cyc_start,
  input logic cyc_dummy
);
  localparam int unsigned MIN_GAP = LAUNCH_LAT + 1;
  localparam int unsigned GW      = $clog2(MIN_GAP + 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)                      gap_q <= GW'(MIN_GAP);
    else if (cyc_start)           gap_q <= GW'(1);
    else if (gap_q < GW'(MIN_GAP)) gap_q <= gap_q + 1'b1;
  end

  // R3
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_start |=> !cyc_start);

  // R3
  start_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> gap_q >= GW'(MIN_GAP));

  // R6
  dummy_with_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc_dummy) |-> cyc_start);

  // R7
  dummy_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc_dummy) |-> $past(single_addr && burst));

  // R6
  dummy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_dummy && cyc_done) |=> !cyc_dummy);
endmodule

bind dreq_launcher dreq_launcher_chk #(.LAUNCH_LAT(LAUNCH_LAT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .single_addr (single_addr),
  .burst       (burst),
  .cyc_done    (cyc_done),
  .cyc_start   (cyc_start),
  .cyc_dummy   (cyc_dummy)
);

// File: tb/sim_dreq_launcher.sv
`timescale 1ns/1ps
module sim_dreq_launcher;
  logic clk = 1'b0;
  logic rst, en, req_n, det_level, single_addr, burst, cyc_done;
  logic cyc_start, cyc_dummy;
  int   n_chk = 0;
  int   n_fail = 0;

  always #4 clk = ~clk;

  dreq_launcher u0 (
    .clk(clk), .rst(rst), .en(en), .req_n(req_n), .det_level(det_level),
    .single_addr(single_addr), .burst(burst), .cyc_done(cyc_done),
    .cyc_start(cyc_start), .cyc_dummy(cyc_dummy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // counts rising edges until cyc_start is seen (max if never)
  task automatic wait_start(input int max, output int n);
    n = 0;
    while (n < max) begin
      step();
      n++;
      if (cyc_start) break;
    end
  endtask

  // pulse cyc_done, report dummy right after, count edges to next start
  task automatic done_count(input int max, output int n, output int dum_after);
    cyc_done = 1'b1;
    step();
    cyc_done = 1'b0;
    n = 1;
    dum_after = int'(cyc_dummy);
    while (n < max && !cyc_start) begin
      step();
      n++;
    end
  endtask

  task automatic quiet(input int cycles, input string req);
    int hits = 0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (cyc_start) hits++;
    end
    chk(hits == 0, req, "unexpected starts", hits, 0);
  endtask

  task automatic config_set(input bit lvl, input bit sa, input bit bu);
    det_level = lvl; single_addr = sa; burst = bu;
    step();
  endtask

  task automatic t_reset();
    int n;
    rst = 1'b1; en = 1'b1; req_n = 1'b1; cyc_done = 1'b0;
    det_level = 1'b0; single_addr = 1'b0; burst = 1'b0;
    repeat (4) step();
    chk(cyc_start == 1'b0, "R1", "start in reset", int'(cyc_start), 0);
    chk(cyc_dummy == 1'b0, "R1", "dummy in reset", int'(cyc_dummy), 0);
    rst = 1'b0;
    wait_start(12, n);
    chk(n == 12, "R1", "start with idle pin", n, 12);
  endtask

  task automatic t_edge_latency();
    int n, d;
    config_set(1'b0, 1'b0, 1'b0);
    req_n = 1'b0;
    wait_start(20, n);
    chk(n == 6, "R2", "edges from pin fall to start", n, 6);
    chk(cyc_dummy == 1'b0, "R7", "dummy in dual cycle-steal", int'(cyc_dummy), 0);
    step();
    chk(cyc_start == 1'b0, "R3", "start width", int'(cyc_start), 0);
    quiet(6, "R3");
    done_count(20, n, d);
    chk(n == 20, "R4", "relaunch with pin held low in edge mode", n, 20);
    req_n = 1'b1;
    quiet(4, "R4");
  endtask

  task automatic t_edge_collapse();
    int n, d;
    config_set(1'b0, 1'b0, 1'b1);
    req_n = 1'b0;
    wait_start(20, n);
    chk(n == 6, "R2", "first start", n, 6);
    for (int k = 0; k < 2; k++) begin
      req_n = 1'b1; repeat (3) step();
      req_n = 1'b0; repeat (3) step();
    end
    req_n = 1'b1;
    done_count(20, n, d);
    chk(n == 5, "R4", "pending launch after done", n, 5);
    chk(d == 0, "R7", "dummy in dual burst", d, 0);
    done_count(20, n, d);
    chk(n == 20, "R4", "merged edges launched twice", n, 20);
  endtask

  task automatic t_level();
    int n, d;
    config_set(1'b1, 1'b0, 1'b1);
    req_n = 1'b0;
    wait_start(20, n);
    chk(n == 6, "R2", "level-mode latency", n, 6);
    for (int k = 0; k < 2; k++) begin
      done_count(20, n, d);
      chk(n == 5, "R5", "relaunch while low", n, 5);
      chk(cyc_dummy == 1'b0, "R7", "dummy in dual level burst", int'(cyc_dummy), 0);
    end
    req_n = 1'b1;
    repeat (4) step();
    done_count(20, n, d);
    chk(n == 20, "R5", "launch after pin high", n, 20);
  endtask

  task automatic t_dummy_edge();
    int n, d;
    config_set(1'b0, 1'b1, 1'b1);
    req_n = 1'b0;
    wait_start(20, n);
    chk(n == 6, "R2", "dummy start latency", n, 6);
    chk(cyc_dummy == 1'b1, "R6", "first cycle dummy", int'(cyc_dummy), 1);
    repeat (3) step();
    chk(cyc_dummy == 1'b1, "R6", "dummy held until done", int'(cyc_dummy), 1);
    done_count(20, n, d);
    chk(d == 0, "R6", "dummy after its done", d, 0);
    chk(n == 4, "R6", "data cycle after dummy", n, 4);
    chk(cyc_dummy == 1'b0, "R6", "data cycle flag", int'(cyc_dummy), 0);
    req_n = 1'b1;
    done_count(20, n, d);
    chk(n == 20, "R6", "extra launch after data cycle", n, 20);
  endtask

  task automatic t_level_seq();
    int n, d;
    config_set(1'b1, 1'b1, 1'b1);
    req_n = 1'b0;
    wait_start(20, n);
    chk(cyc_dummy == 1'b1, "R8", "sequence opens with dummy", int'(cyc_dummy), 1);
    done_count(20, n, d);
    chk(n == 4 && cyc_dummy == 1'b0, "R8", "data cycle edges", n, 4);
    done_count(20, n, d);
    chk(n == 5, "R8", "continued launch edges", n, 5);
    chk(cyc_dummy == 1'b0, "R8", "dummy inside sequence", int'(cyc_dummy), 0);
    req_n = 1'b1;
    repeat (4) step();
    done_count(10, n, d);
    chk(n == 10, "R5", "launch after release", n, 10);
    req_n = 1'b0;
    wait_start(20, n);
    chk(n == 6, "R8", "new sequence latency", n, 6);
    chk(cyc_dummy == 1'b1, "R8", "new sequence dummy", int'(cyc_dummy), 1);
    done_count(20, n, d);
    chk(n == 4, "R8", "new sequence data cycle", n, 4);
    req_n = 1'b1;
    repeat (4) step();
    done_count(10, n, d);
  endtask

  task automatic t_steal_single();
    int n, d;
    config_set(1'b0, 1'b1, 1'b0);
    req_n = 1'b0;
    wait_start(20, n);
    chk(n == 6, "R2", "cycle-steal latency", n, 6);
    chk(cyc_dummy == 1'b0, "R7", "dummy in single cycle-steal", int'(cyc_dummy), 0);
    req_n = 1'b1;
    done_count(15, n, d);
    chk(n == 15, "R7", "second cycle in cycle steal", n, 15);
  endtask

  task automatic t_enable();
    int n, d;
    config_set(1'b0, 1'b0, 1'b0);
    en = 1'b0;
    req_n = 1'b0;
    quiet(20, "R9");
    req_n = 1'b1;
    en = 1'b1;
    wait_start(20, n);
    chk(n == 4, "R9", "held edge after enable", n, 4);
    done_count(12, n, d);
    chk(n == 12, "R9", "second launch", n, 12);
  endtask

  task automatic t_done_ignored();
    int n;
    config_set(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) begin
      cyc_done = 1'b1; step(); cyc_done = 1'b0; step();
    end
    chk(cyc_start == 1'b0, "R10", "start from idle done", int'(cyc_start), 0);
    req_n = 1'b0;
    n = 0;
    while (n < 20) begin
      cyc_done = (n == 4);
      step();
      n++;
      if (cyc_start) break;
    end
    cyc_done = 1'b0;
    chk(n == 6, "R10", "latency with done in wait", n, 6);
    step();
    chk(cyc_start == 1'b0, "R10", "cycle still running", int'(cyc_start), 0);
    req_n = 1'b1;
    begin
      int m, d;
      done_count(12, m, d);
      chk(m == 12, "R10", "no launch after done", m, 12);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_edge_latency();
    t_edge_collapse();
    t_level();
    t_dummy_edge();
    t_level_seq();
    t_steal_single();
    t_enable();
    t_done_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule